// File: doc/BRIEF.md
# Atomic Reduction Read-Modify-Write Unit

This unit sits beside a memory and applies one integer reduction to a single 64-bit word without interruption. An issuer hands it a request made of an opcode, a data type, a word address and an operand. The issuer uses a valid/ready handshake and does not wait for the result. Accepted requests wait in a small first-in first-out pending table. A single engine takes them from the table one at a time. For each one it reads the word from a synchronous memory port, forms the new value, and writes that value back to the same word. Because there is only one engine, no other access to any location can fall between a read and its write. Requests to the same address also complete in the order they were issued.

The engine is a four-state machine:
- `ST_IDLE`: the engine waits for work. When the table is not empty it pops the oldest entry and goes to `ST_READ`.
- `ST_READ`: the engine drives the read strobe for the captured address. It always moves to `ST_CALC`.
- `ST_CALC`: the read data is present and the result is formed. If the opcode/type pair is legal the engine goes to `ST_WRITE`. If the pair is illegal it returns to `ST_IDLE` and does not write.
- `ST_WRITE`: the engine drives the write strobe with the result. It always returns to `ST_IDLE`.

Opcode encoding: 0 add, 1 minimum, 2 maximum, 3 bounded increment, 4 bounded decrement, 5 and, 6 or, 7 xor. Type encoding: 0 unsigned 32, 1 signed 32, 2 unsigned 64, 3 signed 64.

Top module: `red_rmw_unit`

## Requirements
- R1: Opcode 0 writes back the stored value plus the operand, modulo 2^32 for the 32-bit types (0, 1) and modulo 2^64 for the 64-bit types (2, 3).
- R2: Opcodes 5, 6 and 7 write back the bitwise AND, OR and XOR of the stored value and the operand, for every type.
- R3: Opcodes 1 and 2 write back the smaller (1) or the larger (2) of the stored value and the operand. Types 1 and 3 compare as two's complement numbers. Types 0 and 2 compare as unsigned numbers.
- R4: Opcode 3 with type 0 writes 0 when the low 32 bits of the stored value are greater than or equal to the low 32 bits of the operand. Otherwise it writes the stored value plus one.
- R5: Opcode 4 with type 0 writes the operand's low 32 bits when the stored low 32 bits are zero or greater than the operand's. Otherwise it writes the stored value minus one.
- R6: Opcode 3 or 4 paired with any type other than 0 performs no write, so memory is left unchanged.
- R7: For types 0 and 1, only bits 31:0 of the word change. Bits 63:32 are written back exactly as they were read.
- R8: Every write goes to the address that was read exactly two cycles earlier. There is no read or write in the cycle between them, and read and write are never strobed together.
- R9: Requests to the same address take effect in issue order. Each one operates on the value the previous one wrote.
- R10: The pending table holds up to DEPTH accepted requests. req_ready is low while the table is full and high otherwise.
- R11: During reset and directly after it, req_ready is high and no memory strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Pending table can accept a request |
| req_op | input | 3 | Reduction opcode |
| req_type | input | 2 | Data type code |
| req_addr | input | AW | Word address |
| req_operand | input | 64 | Operand value |
| mem_rd_en | output | 1 | Memory read strobe; data returns one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address for read and write |
| mem_rd_data | input | 64 | Read data, valid the cycle after mem_rd_en |
| mem_wr_data | output | 64 | Write data |

## Verification
The bench sweeps every opcode and type against a grid of stored values and operands. The grid is chosen to hit the edge cases: sign-bit boundaries, all-ones words, equal values and zero.
- A design that compares unsigned for the signed types returns the wrong minimum or maximum whenever exactly one sign bit is set.
- A design that drops the zero test in the decrement leaves 0 wrapping to all ones instead of loading the bound.
- A 32-bit operation that zeroes or carries into the upper half shows up in bits 63:32.
- Illegal increment/decrement pairs are caught if they write anything at all.
- Bursts to one address catch an engine that overlaps a read with the previous write: it loses an update, so the final count comes out short.

// File: rtl/red_pkg.sv
package red_pkg;

    localparam int DW = 64;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_MIN = 3'd1,
        OP_MAX = 3'd2,
        OP_INC = 3'd3,
        OP_DEC = 3'd4,
        OP_AND = 3'd5,
        OP_OR  = 3'd6,
        OP_XOR = 3'd7
    } red_op_e;

    typedef enum logic [1:0] {
        TY_U32 = 2'd0,
        TY_S32 = 2'd1,
        TY_U64 = 2'd2,
        TY_S64 = 2'd3
    } red_ty_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE
    } red_st_e;

endpackage

// File: rtl/red_req_queue.sv
module red_req_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [PW:0]   CAP  = (PW + 1)'(DEPTH);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CAP);
    assign dout  = slot_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push && !full) begin
                slot_q[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop && !empty)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push && !full, pop && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/red_alu.sv
module red_alu
    import red_pkg::*;
(
    input  red_op_e       op,
    input  red_ty_e       ty,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] operand,
    output logic          ok,
    output logic [DW-1:0] result
);
    logic          wide, sgn, lt;
    logic [DW:0]   ma, ob;
    logic [31:0]   m32, b32;
    logic [DW-1:0] raw;

    assign wide = (ty == TY_U64) || (ty == TY_S64);
    assign sgn  = (ty == TY_S32) || (ty == TY_S64);
    assign m32  = mem_val[31:0];
    assign b32  = operand[31:0];
    // Extend both to 65 bits so one signed compare covers all four types
    assign ma   = wide ? {sgn & mem_val[DW-1], mem_val}
                       : {{(DW-31){sgn & m32[31]}}, m32};
    assign ob   = wide ? {sgn & operand[DW-1], operand}
                       : {{(DW-31){sgn & b32[31]}}, b32};
    assign lt   = $signed(ma) < $signed(ob);
    assign ok   = !(((op == OP_INC) || (op == OP_DEC)) && (ty != TY_U32));

    always_comb begin
        unique case (op)
            OP_ADD: raw = mem_val + operand;
            OP_MIN: raw = lt ? mem_val : operand;
            OP_MAX: raw = lt ? operand : mem_val;
            OP_INC: raw = {32'd0, (m32 >= b32) ? 32'd0 : m32 + 32'd1};
            OP_DEC: raw = {32'd0, ((m32 == 32'd0) || (m32 > b32)) ? b32 : m32 - 32'd1};
            OP_AND: raw = mem_val & operand;
            OP_OR:  raw = mem_val | operand;
            OP_XOR: raw = mem_val ^ operand;
            default: raw = '0;
        endcase
    end

    assign result = wide ? raw : {mem_val[DW-1:32], raw[31:0]};

endmodule

// File: rtl/red_rmw_unit.sv
module red_rmw_unit
    import red_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [1:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_operand,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic [DW-1:0] mem_wr_data
);
    localparam int EW = 3 + 2 + AW + DW;

    red_st_e       st, nxt;
    logic [EW-1:0] head;
    logic          q_empty, q_full, pop;
    red_op_e       cur_op;
    red_ty_e       cur_ty;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_opnd, cur_res, alu_res;
    logic          alu_ok;

    red_req_queue #(.W(EW), .DEPTH(DEPTH)) i_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_valid && req_ready),
        .din   ({req_op, req_type, req_addr, req_operand}),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    red_alu i_alu (
        .op      (cur_op),
        .ty      (cur_ty),
        .mem_val (mem_rd_data),
        .operand (cur_opnd),
        .ok      (alu_ok),
        .result  (alu_res)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (!q_empty) nxt = ST_READ;
            ST_READ:  nxt = ST_CALC;
            ST_CALC:  nxt = alu_ok ? ST_WRITE : ST_IDLE;
            ST_WRITE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pop         = (st == ST_IDLE) && !q_empty;
        mem_rd_en   = (st == ST_READ);
        mem_wr_en   = (st == ST_WRITE);
        mem_addr    = cur_addr;
        mem_wr_data = cur_res;
        req_ready   = !q_full;
    end

    // Operation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op   <= OP_ADD;
            cur_ty   <= TY_U32;
            cur_addr <= '0;
            cur_opnd <= '0;
            cur_res  <= '0;
        end else begin
            if (pop) begin
                cur_op   <= red_op_e'(head[EW-1 -: 3]);
                cur_ty   <= red_ty_e'(head[EW-4 -: 2]);
                cur_addr <= head[DW +: AW];
                cur_opnd <= head[DW-1:0];
            end
            if (st == ST_CALC) cur_res <= alu_res;
        end
    end

endmodule

// File: rtl/red_rmw_chk.sv
module red_rmw_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr
);
    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R8
    atomic_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en, 2) && ($past(mem_addr, 2) == mem_addr)
                       && !$past(mem_rd_en) && !$past(mem_wr_en)));

    // R8
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!mem_rd_en && !mem_wr_en));

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

endmodule

bind red_rmw_unit red_rmw_chk #(.AW(AW)) i_red_rmw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr)
);

// File: tb/test_red_rmw_unit.sv
module test_red_rmw_unit;
    localparam int AW    = 10;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [1:0]    req_type = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_operand = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_rd_data = '0;
    logic [63:0]   mem_wr_data;

    logic [63:0]   mem_m [1 << AW];
    int            total = 0, fails = 0, wr_cnt = 0, seq_err = 0, rst_act = 0;
    bit            stall_seen = 1'b0, done = 1'b0;
    logic          rd_d1 = 1'b0, rd_d2 = 1'b0;
    logic [AW-1:0] a_d1 = '0, a_d2 = '0;

    always #2 clk = ~clk;

    red_rmw_unit #(.AW(AW), .DEPTH(DEPTH)) i_red_rmw_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_type(req_type), .req_addr(req_addr),
        .req_operand(req_operand), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data)
    );

    // Synchronous memory model and access monitor
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_m[mem_addr];
        if (mem_wr_en) begin
            mem_m[mem_addr] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
            if (!(rd_d2 && a_d2 == mem_addr && !rd_d1)) seq_err <= seq_err + 1;
        end
        if (!rst_n && (mem_rd_en || mem_wr_en)) rst_act <= rst_act + 1;
        rd_d2 <= rd_d1; a_d2 <= a_d1;
        rd_d1 <= mem_rd_en; a_d1 <= mem_addr;
    end

    always @(negedge clk) if (req_valid && !req_ready) stall_seen = 1'b1;

    task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // Reference: returns {ok, new_value}
    function automatic logic [64:0] ref_op(int op, int ty, logic [63:0] m, logic [63:0] b);
        logic [63:0] r;
        logic [31:0] lo, bl;
        bit less, w, s;
        w  = (ty >= 2);
        s  = (ty == 1) || (ty == 3);
        lo = m[31:0];
        bl = b[31:0];
        if (w) less = s ? ($signed(m) < $signed(b)) : (m < b);
        else   less = s ? ($signed(lo) < $signed(bl)) : (lo < bl);
        if ((op == 3 || op == 4) && ty != 0) return {1'b0, m};
        case (op)
            0: r = w ? m + b : {m[63:32], lo + bl};
            1: r = less ? m : b;
            2: r = less ? b : m;
            3: r = {32'd0, (lo >= bl) ? 32'd0 : lo + 32'd1};
            4: r = {32'd0, (lo == 0 || lo > bl) ? bl : lo - 32'd1};
            5: r = m & b;
            6: r = m | b;
            default: r = m ^ b;
        endcase
        if (!w) r = {m[63:32], r[31:0]};
        return {1'b1, r};
    endfunction

    function automatic logic [63:0] grid(int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'h0000_0000_7FFF_FFFF;
            3: return 64'h1234_5678_8000_0000;
            4: return 64'hFFFF_FFFF_FFFF_FFFF;
            5: return 64'h8000_0000_0000_0005;
            default: return 64'hABCD_0000_0000_0003;
        endcase
    endfunction

    // Called at a negedge; returns at the negedge after the handshake edge
    task automatic push(input int op, input int ty, input int a, input logic [63:0] b);
        req_op = 3'(op); req_type = 2'(ty); req_addr = AW'(a); req_operand = b;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        repeat (4) @(negedge clk);
        // R11: reset state
        check(req_ready === 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && !mem_rd_en && !mem_wr_en && rst_act == 0,
              "R11 idle after reset", {62'd0, mem_rd_en, mem_wr_en}, 64'd0);

        // R1 R2 R3 R4 R5 R6 R7: sweep opcode x type x value grid
        for (int op = 0; op < 8; op++)
            for (int ty = 0; ty < 4; ty++)
                for (int i = 0; i < 7; i++)
                    for (int j = 0; j < 7; j++) begin
                        logic [64:0] e;
                        int wc0, a;
                        string tag;
                        a = (op * 4 + ty) % 37 + 1;
                        e = ref_op(op, ty, grid(i), grid(j));
                        mem_m[a] = grid(i);
                        wc0 = wr_cnt;
                        push(op, ty, a, grid(j));
                        req_valid = 1'b0;
                        repeat (7) @(negedge clk);
                        case (op)
                            0: tag = (ty < 2) ? "R1/R7 add" : "R1 add";
                            1, 2: tag = (ty < 2) ? "R3/R7 min-max" : "R3 min-max";
                            3: tag = (ty == 0) ? "R4 inc" : "R6 inc illegal";
                            4: tag = (ty == 0) ? "R5 dec" : "R6 dec illegal";
                            default: tag = (ty < 2) ? "R2/R7 logic" : "R2 logic";
                        endcase
                        check(mem_m[a] === e[63:0] && (wr_cnt - wc0) == (e[64] ? 1 : 0),
                              tag, mem_m[a], e[63:0]);
                    end

        // R9 R10: burst of bounded increments to one address
        mem_m[5] = 64'h0;
        stall_seen = 1'b0;
        for (int k = 0; k < 8; k++) push(3, 0, 5, 64'd10);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(mem_m[5] === 64'd8, "R9 same-address increments in order", mem_m[5], 64'd8);
        check(stall_seen, "R10 ready low when table full", 64'(stall_seen), 64'd1);
        check(req_ready === 1'b1, "R10 ready back after drain", 64'(req_ready), 64'd1);

        // R9: mixed ops to one address, order-dependent result
        mem_m[7] = 64'h0;
        push(0, 2, 7, 64'd100);
        push(2, 2, 7, 64'd50);
        push(4, 0, 7, 64'd3);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(mem_m[7] === 64'd3, "R9 add-max-dec order", mem_m[7], 64'd3);

        // R9: interleaved addresses each see their own chain
        mem_m[8] = 64'd1; mem_m[9] = 64'd2;
        push(0, 2, 8, 64'd4);
        push(0, 2, 9, 64'd8);
        push(5, 2, 8, 64'd4);
        push(6, 2, 9, 64'd1);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(mem_m[8] === 64'd4, "R9 interleave addr 8", mem_m[8], 64'd4);
        check(mem_m[9] === 64'd11, "R9 interleave addr 9", mem_m[9], 64'd11);

        // R8: every write preceded by its read two cycles earlier
        check(seq_err == 0, "R8 read-write sequence", 64'(seq_err), 64'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule